// File: doc/BRIEF.md
# Repeater Expansion Bus Node Interface

This block is the per-chip side of a shared expansion bus that lets several repeater chips behave as a single multiport repeater. All chips run from one common clock, and each bus cycle is one clock period. A node raises its request line while any of its own ports is active. It watches the grant and contention lines from an external arbiter. When it alone holds the bus, it drives the shared data and jam lines through output enables.

While it owns the bus, the node sends repeated data in NRZ form. When a local collision appears, it raises the jam line and reuses the data line as a flag: high when at most one local port is colliding, low when several are. After a runt or fragment it holds this single-port flag for one extra cycle before it lets go of the request. When the arbiter reports contention, every requesting node jams without driving the bus. The first granted cycle after contention is an undriven transitional cycle. After it, the surviving node takes the bus again as a jamming owner. An idle node follows the jam line that another owner drives and decodes the single-port flag.

The control is a state machine with these states: IDLE (no request), ARB (requesting, waiting for a clean grant), MASTER (owns the bus, repeating data), MJAM (owns the bus, jamming), CJAM (bus contention, jamming without driving) and TAIL (one closing cycle of the single-port flag). Transitions:
- IDLE to ARB: a port becomes active.
- ARB to MASTER: a clean grant with no local collision.
- ARB to MJAM: a clean grant while a local collision is present.
- ARB, MASTER or MJAM to CJAM: contention is reported.
- MASTER to MJAM: a local collision appears.
- MJAM to TAIL: activity ends.
- TAIL to IDLE: the closing cycle is done. TAIL goes to CJAM instead if contention and activity are both present.
- CJAM to MJAM: a clean grant, which is the transitional cycle.
- ARB, MASTER or CJAM to IDLE: activity ends.

Top module: `xbus_node`

## Requirements
- R1: After reset, and while reset is held, req, dat_oe, jam_oe, dat_out, jam_out, jam_tx and remote_one_left are all 0.
- R2: req goes to 1 one cycle after any port_act bit is sampled high from IDLE. In ARB, MASTER or CJAM, req goes to 0 one cycle after all port_act bits are sampled low.
- R3: dat_oe and jam_oe rise only in the cycle after a cycle in which ack=1 and col=0 were sampled. The two enables are always equal.
- R4: In MASTER, jam_out=0 and dat_out equals rx_bit as sampled at the previous edge.
- R5: While the node owns the bus and any port_col bit is set, jam_out=1 and jam_tx=1. dat_out=1 if at most one port_col bit is set, and 0 if two or more are set.
- R6: When activity ends in MJAM, the node spends one cycle with req=1, jam_out=1 and dat_out=1 (driven), then drops req.
- R7: If col is sampled high while requesting and active, the next cycle has dat_oe=jam_oe=0 and jam_tx=1.
- R8: The first cycle with ack=1 and col=0 after contention is undriven, with jam_tx=1. From the next cycle the node drives jam_out=1 until it drops req.
- R9: If activity ends during contention, req drops on the next cycle and the node does not drive the bus.
- R10: The enables fall at the same edge at which req falls.
- R11: In IDLE, jam_tx follows the jam line driven by another node one cycle later. remote_one_left is 1 when that jam line and the data line were both sampled high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bus clock, one bus cycle per period |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| port_act | input | NPORTS | Per-port receive activity |
| port_col | input | NPORTS | Per-port collision detect |
| rx_bit | input | 1 | Data bit to repeat from the active port |
| ack | input | 1 | Arbiter grant (exactly one requester) |
| col | input | 1 | Arbiter contention (two or more requesters) |
| dat_in | input | 1 | Observed level of the shared data line |
| jam_in | input | 1 | Observed level of the shared jam line |
| req | output | 1 | Bus request |
| dat_out | output | 1 | Value driven onto the data line |
| dat_oe | output | 1 | Output enable for the data line |
| jam_out | output | 1 | Value driven onto the jam line |
| jam_oe | output | 1 | Output enable for the jam line |
| jam_tx | output | 1 | Tells the port transmitters to send jam |
| remote_one_left | output | 1 | Another owner reports a single-port collision |

## Verification
The bench builds the node with NPORTS=3. With three ports, a one-port collision, a two-port collision and a collision with no active collision flag can all be written in short vectors. The bench models a second node as a single request bit, so the arbiter's grant and contention are the exclusive-or and the and of the two requests. Runt closing, contention entry and back-off, and the undriven transitional cycle can then all be reached in a few cycles each.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        XS_IDLE   = 3'd0,
        XS_ARB    = 3'd1,
        XS_MASTER = 3'd2,
        XS_MJAM   = 3'd3,
        XS_CJAM   = 3'd4,
        XS_TAIL   = 3'd5
    } xbus_state_e;

    typedef struct packed {
        logic req;
        logic oe;
        logic jam;
        logic dat;
        logic jam_tx;
        logic one_left_rx;
    } xbus_out_t;

endpackage

// File: rtl/xbus_port_eval.sv
module xbus_port_eval #(
    parameter int NPORTS = 4
) (
    input  logic [NPORTS-1:0] port_act,
    input  logic [NPORTS-1:0] port_col,
    output logic              any_act,
    output logic              any_col,
    output logic              one_left
);
    localparam int CW = $clog2(NPORTS + 1);

    assign any_act = |port_act;
    assign any_col = |port_col;

    generate
        if (NPORTS == 1) begin : g_single
            assign one_left = 1'b1;
        end else begin : g_count
            logic [CW-1:0] col_count;
            always_comb begin
                col_count = '0;
                for (int i = 0; i < NPORTS; i++) begin
                    col_count = col_count + CW'(port_col[i]);
                end
            end
            assign one_left = (col_count <= CW'(1));
        end
    endgenerate

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        any_act,
    input  logic        any_col,
    input  logic        ack,
    input  logic        col,
    output xbus_state_e state_d
);
    xbus_state_e state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: begin
                if (any_act) state_d = XS_ARB;
            end
            XS_ARB: begin
                if (!any_act)  state_d = XS_IDLE;
                else if (col)  state_d = XS_CJAM;
                else if (ack)  state_d = any_col ? XS_MJAM : XS_MASTER;
            end
            XS_MASTER: begin
                if (!any_act)     state_d = XS_IDLE;
                else if (col)     state_d = XS_CJAM;
                else if (any_col) state_d = XS_MJAM;
            end
            XS_MJAM: begin
                if (col)           state_d = XS_CJAM;
                else if (!any_act) state_d = XS_TAIL;
            end
            XS_CJAM: begin
                if (!any_act)        state_d = XS_IDLE;
                else if (ack && !col) state_d = XS_MJAM;
            end
            XS_TAIL: begin
                state_d = (any_act && col) ? XS_CJAM : XS_IDLE;
            end
            default: state_d = XS_IDLE;
        endcase
    end

    // R6: the closing single-port cycle never lasts more than one cycle
    assert_tail_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_TAIL) |=> (state_q != XS_TAIL));

    // R8: a clean grant seen during contention with activity returns to jamming ownership
    assert_trans_to_jam_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_CJAM && any_act && ack && !col) |=> (state_q == XS_MJAM));

endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
    import xbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  xbus_state_e state_d,
    input  logic        one_left,
    input  logic        rx_bit,
    input  logic        dat_in,
    input  logic        jam_in,
    output logic        req,
    output logic        dat_out,
    output logic        dat_oe,
    output logic        jam_out,
    output logic        jam_oe,
    output logic        jam_tx,
    output logic        remote_one_left
);
    xbus_out_t nxt;
    xbus_out_t cur;
    logic      jam_seen;
    logic      dat_seen;

    // only lines driven by another node count as remote status
    assign jam_seen = jam_in & ~cur.oe;
    assign dat_seen = dat_in & ~cur.oe;

    always_comb begin
        nxt = '0;
        unique case (state_d)
            XS_IDLE: begin
                nxt.jam_tx      = jam_seen;
                nxt.one_left_rx = jam_seen & dat_seen;
            end
            XS_ARB: begin
                nxt.req = 1'b1;
            end
            XS_MASTER: begin
                nxt.req = 1'b1;
                nxt.oe  = 1'b1;
                nxt.dat = rx_bit;
            end
            XS_MJAM: begin
                nxt.req    = 1'b1;
                nxt.oe     = 1'b1;
                nxt.jam    = 1'b1;
                nxt.dat    = one_left;
                nxt.jam_tx = 1'b1;
            end
            XS_CJAM: begin
                nxt.req    = 1'b1;
                nxt.jam_tx = 1'b1;
            end
            XS_TAIL: begin
                nxt.req    = 1'b1;
                nxt.oe     = 1'b1;
                nxt.jam    = 1'b1;
                nxt.dat    = 1'b1;
                nxt.jam_tx = 1'b1;
            end
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= '0;
        else        cur <= nxt;
    end

    assign req             = cur.req;
    assign dat_oe          = cur.oe;
    assign jam_oe          = cur.oe;
    assign dat_out         = cur.dat;
    assign jam_out         = cur.jam;
    assign jam_tx          = cur.jam_tx;
    assign remote_one_left = cur.one_left_rx;

    // R5: a raised jam line is always owned and paired with local jamming
    assert_jam_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        jam_out |-> (jam_oe && jam_tx && req));

    // R11: remote status is only reported while not requesting
    assert_remote_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        remote_one_left |-> (!req && jam_tx));

endmodule

// File: rtl/xbus_node.sv
module xbus_node
    import xbus_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] port_act,
    input  logic [NPORTS-1:0] port_col,
    input  logic              rx_bit,
    input  logic              ack,
    input  logic              col,
    input  logic              dat_in,
    input  logic              jam_in,
    output logic              req,
    output logic              dat_out,
    output logic              dat_oe,
    output logic              jam_out,
    output logic              jam_oe,
    output logic              jam_tx,
    output logic              remote_one_left
);
    logic        any_act;
    logic        any_col;
    logic        one_left;
    xbus_state_e state_d;

    xbus_port_eval #(.NPORTS(NPORTS)) u_eval (
        .port_act (port_act),
        .port_col (port_col),
        .any_act  (any_act),
        .any_col  (any_col),
        .one_left (one_left)
    );

    xbus_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_act (any_act),
        .any_col (any_col),
        .ack     (ack),
        .col     (col),
        .state_d (state_d)
    );

    xbus_drive u_drive (
        .clk             (clk),
        .rst_n           (rst_n),
        .state_d         (state_d),
        .one_left        (one_left),
        .rx_bit          (rx_bit),
        .dat_in          (dat_in),
        .jam_in          (jam_in),
        .req             (req),
        .dat_out         (dat_out),
        .dat_oe          (dat_oe),
        .jam_out         (jam_out),
        .jam_oe          (jam_oe),
        .jam_tx          (jam_tx),
        .remote_one_left (remote_one_left)
    );

    // R3: driving starts only after a clean grant was sampled
    assert_grant_before_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_oe) |-> $past(ack && !col));

    // R7: contention while active forces undriven jamming next cycle
    assert_contention_jam_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && col && any_act) |=> (jam_tx && !dat_oe && !jam_oe));

    // R10: bus lines are released at the edge that drops the request
    assert_release_with_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> (!dat_oe && !jam_oe));

    // R6: a request that ends after jamming ends with the single-port flag
    assert_tail_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req) && $past(jam_out)) |-> $past(dat_out));

    // R9: contention with no activity left means no driving next cycle
    assert_backoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && col && !any_act) |=> !dat_oe);

endmodule

// File: tb/sim_xbus_node.sv
module sim_xbus_node;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] port_act;
    logic [NP-1:0] port_col;
    logic          rx_bit;
    logic          peer_req, peer_jam, peer_dat;
    logic          ack, col, dat_in, jam_in;
    logic          req, dat_out, dat_oe, jam_out, jam_oe, jam_tx, remote_one_left;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // arbiter and shared lines modelled with one other node
    assign ack    = req ^ peer_req;
    assign col    = req & peer_req;
    assign dat_in = dat_oe ? dat_out : peer_dat;
    assign jam_in = jam_oe ? jam_out : peer_jam;

    xbus_node #(.NPORTS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .port_act(port_act), .port_col(port_col),
        .rx_bit(rx_bit), .ack(ack), .col(col), .dat_in(dat_in), .jam_in(jam_in),
        .req(req), .dat_out(dat_out), .dat_oe(dat_oe), .jam_out(jam_out),
        .jam_oe(jam_oe), .jam_tx(jam_tx), .remote_one_left(remote_one_left)
    );

    // {tag, act, pcol, rx, peer_req, peer_jam, peer_dat, e_req, e_oe, e_jam, e_dat, e_jtx, e_rol}
    localparam int NV = 28;
    localparam logic [19:0] VEC [NV] = '{
        {4'd2,  3'b000, 3'b000, 4'b0000, 6'b000000}, // R2 idle stays quiet
        {4'd2,  3'b001, 3'b000, 4'b0000, 6'b100000}, // R2 request raised
        {4'd4,  3'b001, 3'b000, 4'b1000, 6'b110100}, // R4 granted, data 1
        {4'd4,  3'b001, 3'b000, 4'b0000, 6'b110000}, // R4 data 0
        {4'd5,  3'b011, 3'b010, 4'b0000, 6'b111110}, // R5 one port colliding
        {4'd5,  3'b011, 3'b011, 4'b0000, 6'b111010}, // R5 two ports colliding
        {4'd6,  3'b000, 3'b000, 4'b0000, 6'b111110}, // R6 runt closing cycle
        {4'd10, 3'b000, 3'b000, 4'b0000, 6'b000000}, // R10 req and enables drop
        {4'd11, 3'b000, 3'b000, 4'b0111, 6'b000011}, // R11 remote single port
        {4'd11, 3'b000, 3'b000, 4'b0110, 6'b000010}, // R11 remote multi port
        {4'd2,  3'b001, 3'b000, 4'b0100, 6'b100000}, // R2 request while peer owns
        {4'd7,  3'b001, 3'b000, 4'b0100, 6'b100010}, // R7 contention
        {4'd7,  3'b001, 3'b000, 4'b0100, 6'b100010}, // R7 contention held
        {4'd8,  3'b001, 3'b000, 4'b0000, 6'b111110}, // R8 after transitional cycle
        {4'd8,  3'b001, 3'b000, 4'b0000, 6'b111110}, // R8 keeps jamming
        {4'd6,  3'b000, 3'b000, 4'b0000, 6'b111110}, // R6 closing cycle
        {4'd10, 3'b000, 3'b000, 4'b0000, 6'b000000}, // R10 release
        {4'd2,  3'b001, 3'b000, 4'b0000, 6'b100000}, // R2 request
        {4'd7,  3'b001, 3'b000, 4'b0100, 6'b100010}, // R7 contention
        {4'd9,  3'b000, 3'b000, 4'b0100, 6'b000000}, // R9 back off
        {4'd2,  3'b001, 3'b001, 4'b0000, 6'b100000}, // R2 request with collision
        {4'd5,  3'b001, 3'b001, 4'b0000, 6'b111110}, // R5 grant straight into jam
        {4'd6,  3'b000, 3'b000, 4'b0000, 6'b111110}, // R6 closing cycle
        {4'd10, 3'b000, 3'b000, 4'b0000, 6'b000000}, // R10 release
        {4'd2,  3'b001, 3'b000, 4'b0000, 6'b100000}, // R2 request
        {4'd4,  3'b001, 3'b000, 4'b1000, 6'b110100}, // R4 master data 1
        {4'd7,  3'b001, 3'b000, 4'b1100, 6'b100010}, // R7 owner hit by contention
        {4'd9,  3'b000, 3'b000, 4'b0000, 6'b000000}  // R9 back off
    };

    function automatic logic [5:0] outs();
        return {req, dat_oe, jam_out, dat_out, jam_tx, remote_one_left};
    endfunction

    task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {req,oe,jam,dat,jtx,rol} actual %b expected %b", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; port_act = '0; port_col = '0; rx_bit = 1'b0;
        peer_req = 1'b0; peer_jam = 1'b0; peer_dat = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state", outs(), 6'b0);
        check("R1 enables equal in reset", {5'b0, jam_oe}, {5'b0, dat_oe});
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            port_act = VEC[i][15:13];
            port_col = VEC[i][12:10];
            rx_bit   = VEC[i][9];
            peer_req = VEC[i][8];
            peer_jam = VEC[i][7];
            peer_dat = VEC[i][6];
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i][19:16], i), outs(), VEC[i][5:0]);
            check($sformatf("R3 vector %0d enable pair", i), {5'b0, jam_oe}, {5'b0, dat_oe});
        end

        // R1: reset while owning the bus clears everything at once
        port_act = 3'b001; port_col = '0; peer_req = 1'b0; peer_jam = 1'b0; rx_bit = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R4 master before reset", outs(), 6'b110100);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset during ownership", outs(), 6'b0);
        rst_n = 1'b1;
        port_act = '0;
        @(negedge clk);
        check("R1 idle after reset release", outs(), 6'b0);

        // R3: no grant while contention persists, so no driving
        port_act = 3'b100; peer_req = 1'b1;
        @(negedge clk);
        check("R3 request under peer ownership", outs(), 6'b100000);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R3 no drive during contention", outs(), 6'b100010);
        end
        peer_req = 1'b0; port_act = '0;
        @(negedge clk);
        check("R9 drop request from contention", outs(), 6'b000000);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule